// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Compare Units

This block is a 16-bit up-counter with a set of 16-bit compare registers. A CPU reaches all of them over an 8-bit register bus. Every 16-bit value is moved one byte at a time. A single shared holding byte makes each transfer atomic. On a write, the high byte is parked in the holding byte, and the later low-byte write commits both halves in one cycle. On a read, fetching the low byte also freezes the matching high byte into the holding byte, so the next high-byte read returns a consistent pair.

The counter advances on each cycle in which the timer clock enable is high. On each such cycle it is compared with every compare register. A match sets that unit's interrupt flag and toggles that unit's waveform output. A CPU write to the counter blocks the compare of the next enabled timer cycle in every unit, so reloading the counter never raises a match by accident.

Address map (3-bit address): 0 counter low, 1 counter high, 2 compare A low, 3 compare A high, 4 compare B low, 5 compare B high, 6 flag register.

Top module: `tmr16_cmp_top`

## Requirements
- R1: After synchronous reset, the counter, both compare registers, both flags, both waveform outputs and the read data are all zero.
- R2: The counter adds one on every cycle with `tick_en` high and holds its value when `tick_en` is low.
- R3: The counter wraps from 0xFFFF to 0x0000 on an enabled cycle.
- R4: A write to a high-byte address (1, 3, 5) only loads the holding byte and leaves the register unchanged. A write to a low-byte address (0, 2, 4) loads the register with {holding byte, written byte} in a single cycle.
- R5: A read of a low-byte address returns that register's live low byte and copies its high byte into the holding byte. A read of a high-byte address returns the holding byte. Read data appears on `bus_rdata` one cycle after the `bus_re` strobe.
- R6: There is only one holding byte for all 16-bit registers. A high-byte write to any register, or a low-byte read of any register, changes what the next low-byte write or high-byte read of any other register sees.
- R7: On an enabled timer cycle where the counter (before it advances) equals compare unit x, flag x (`cmp_flag[x]`, bit 0 = A, bit 1 = B) is set and `wave_out[x]` toggles, both visible one cycle later.
- R8: Address 6 reads back the flags in bits 1:0 (bit 0 = A, bit 1 = B). Writing 1 to a bit clears that flag, writing 0 has no effect, and a match in the same cycle wins over the clear.
- R9: A CPU counter low-byte write suppresses the match of the next enabled timer cycle in all compare units, even when the counter equals a compare value. Matches resume on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| tick_en | input | 1 | Timer clock enable |
| cmp_flag | output | 2 | Compare interrupt flags (bit 0 = A, bit 1 = B) |
| wave_out | output | 2 | Compare waveform outputs (bit 0 = A, bit 1 = B) |

## Verification
A read returns its byte on the cycle after the edge that samples `bus_re`. A write takes effect at the edge that samples `bus_we`. A match changes `cmp_flag` and `wave_out` at the same edge that samples the enabled `tick_en`. The bench drives every input on the falling edge and judges the outputs on the next falling edge, so each result is read exactly one register stage after its cause. Each read pushes its expected byte into a queue, and a monitor pops that entry on the falling edge after the strobe was taken. Timer sequences are built tick by tick, so the count at each enabled edge is known exactly. This lets the bench predict each match, including the suppressed one and the match that meets a flag clear in the same cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // Byte lane selected by the least significant address bit
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;

  // Slot index of the counter within the register window
  localparam int unsigned SLOT_COUNTER = 0;
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          cmp_en
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] count_q;
  logic          mute_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      mute_q  <= 1'b0;
    end else if (load_en) begin
      count_q <= load_val;
      mute_q  <= 1'b1;
    end else if (tick_en) begin
      count_q <= count_q + 1'b1;
      mute_q  <= 1'b0;
    end
  end

  assign count  = count_q;
  assign cmp_en = tick_en && !load_en && !mute_q;

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load_en && count_q == CNT_MAX) |=> (count_q == '0))
    else $error("counter did not wrap");

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_en) |=> $stable(count_q))
    else $error("counter moved without tick");

  assert_mute_R9: assert property (@(posedge clk) disable iff (rst)
    (load_en && !rst) |=> !cmp_en)
    else $error("compare enabled right after counter load");
endmodule

// File: rtl/tmr16_cmp_slot.sv
module tmr16_cmp_slot #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          cmp_en,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          flag_clr,
  output logic [CW-1:0] cmp_val,
  output logic          flag,
  output logic          wave
);
  logic [CW-1:0] cmp_q;
  logic          flag_q;
  logic          wave_q;
  logic          hit;

  assign hit = cmp_en && (count == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (load_en) cmp_q <= load_val;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      wave_q <= wave_q ^ hit;
    end
  end

  assign cmp_val = cmp_q;
  assign flag    = flag_q;
  assign wave    = wave_q;

  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q)
    else $error("match did not raise flag");

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !hit) |=> !flag_q)
    else $error("flag clear ignored");

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> (wave_q == $past(wave_q)))
    else $error("wave moved without compare");
endmodule

// File: rtl/tmr16_bus_port.sv
module tmr16_bus_port
  import tmr16_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 3,
  parameter int unsigned NCMP = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     we,
  input  logic                     re,
  input  logic [2*DW-1:0]          count,
  input  logic [NCMP-1:0][2*DW-1:0] cmp_vals,
  input  logic [NCMP-1:0]          flags,
  output logic                     cnt_load,
  output logic [NCMP-1:0]          cmp_load,
  output logic [2*DW-1:0]          load_val,
  output logic [NCMP-1:0]          flag_clr,
  output logic [DW-1:0]            rdata
);
  localparam int unsigned CW = 2 * DW;
  localparam int unsigned IW = AW - 1;
  localparam logic [IW-1:0] FLAG_SLOT = IW'(NCMP + 1);
  localparam logic [IW-1:0] LAST_REG  = IW'(NCMP);

  logic [IW-1:0] slot;
  lane_e         lane;
  logic          is_reg;
  logic          flag_wr;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] rdata_q;
  logic [CW-1:0] slot_val [NCMP+1];
  logic [CW-1:0] sel_val;

  assign slot    = addr[AW-1:1];
  assign lane    = lane_e'(addr[0]);
  assign is_reg  = (slot <= LAST_REG);
  assign flag_wr = we && (slot == FLAG_SLOT) && (lane == LANE_LO);

  assign slot_val[SLOT_COUNTER] = count;
  assign load_val = {hold_q, wdata};
  assign cnt_load = we && (lane == LANE_LO) && (slot == IW'(SLOT_COUNTER));

  for (genvar g = 0; g < NCMP; g++) begin : g_slot
    assign slot_val[g+1] = cmp_vals[g];
    assign cmp_load[g]   = we && (lane == LANE_LO) && (slot == IW'(g + 1));
    assign flag_clr[g]   = flag_wr && wdata[g];
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i <= NCMP; i++) begin
      if (slot == IW'(i)) sel_val = slot_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (we && is_reg && lane == LANE_HI) begin
      hold_q <= wdata;
    end else if (re && is_reg && lane == LANE_LO) begin
      hold_q <= sel_val[CW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      if (is_reg)
        rdata_q <= (lane == LANE_HI) ? hold_q : sel_val[DW-1:0];
      else if (slot == FLAG_SLOT && lane == LANE_LO)
        rdata_q <= {{(DW-NCMP){1'b0}}, flags};
      else
        rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

  assert_hi_read_R5: assert property (@(posedge clk) disable iff (rst)
    (re && is_reg && lane == LANE_HI) |=> (rdata_q == $past(hold_q)))
    else $error("high read did not return holding byte");

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!we && !re) |=> $stable(hold_q))
    else $error("holding byte changed without access");

  assert_one_load_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({cnt_load, cmp_load}) <= 1)
    else $error("more than one register loaded");
endmodule

// File: rtl/tmr16_cmp_top.sv
module tmr16_cmp_top #(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 3,
  parameter int unsigned NCMP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  input  logic            tick_en,
  output logic [NCMP-1:0] cmp_flag,
  output logic [NCMP-1:0] wave_out
);
  localparam int unsigned CW = 2 * DW;

  logic [CW-1:0]            count;
  logic                     cmp_en;
  logic                     cnt_load;
  logic [NCMP-1:0]          cmp_load;
  logic [CW-1:0]            load_val;
  logic [NCMP-1:0]          flag_clr;
  logic [NCMP-1:0][CW-1:0]  cmp_vals;

  tmr16_bus_port #(.DW(DW), .AW(AW), .NCMP(NCMP)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .we       (bus_we),
    .re       (bus_re),
    .count    (count),
    .cmp_vals (cmp_vals),
    .flags    (cmp_flag),
    .cnt_load (cnt_load),
    .cmp_load (cmp_load),
    .load_val (load_val),
    .flag_clr (flag_clr),
    .rdata    (bus_rdata)
  );

  tmr16_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .load_en  (cnt_load),
    .load_val (load_val),
    .count    (count),
    .cmp_en   (cmp_en)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    tmr16_cmp_slot #(.CW(CW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .count    (count),
      .cmp_en   (cmp_en),
      .load_en  (cmp_load[g]),
      .load_val (load_val),
      .flag_clr (flag_clr[g]),
      .cmp_val  (cmp_vals[g]),
      .flag     (cmp_flag[g]),
      .wave     (wave_out[g])
    );
  end
endmodule

// File: tb/tb_tmr16_cmp_top.sv
module tb_tmr16_cmp_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       tick_en = 1'b0;
  logic [1:0] cmp_flag;
  logic [1:0] wave_out;

  int checks = 0;
  int failures = 0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } rd_item_t;
  rd_item_t exp_q[$];
  logic     rd_seen = 1'b0;

  always #5 clk = ~clk;

  tmr16_cmp_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Monitor: a read strobe taken at a rising edge yields data checked at the next falling edge
  always @(posedge clk) rd_seen <= bus_re;
  always @(negedge clk) begin
    if (rd_seen) begin
      rd_item_t it;
      if (exp_q.size() == 0) begin
        check("queue underflow", 16'h1, 16'h0);
      end else begin
        it = exp_q.pop_front();
        check(it.tag, {8'h00, bus_rdata}, {8'h00, it.exp});
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.tag = tag; it.exp = e;
    exp_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    bus_wr(lo + 3'd1, v[15:8]);
    bus_wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] lo, input logic [15:0] v, input string tag);
    bus_rd(lo, v[7:0], tag);
    bus_rd(lo + 3'd1, v[15:8], tag);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    check("R1 flags", {14'd0, cmp_flag}, 16'h0);
    check("R1 wave", {14'd0, wave_out}, 16'h0);
    check("R1 rdata", {8'd0, bus_rdata}, 16'h0);
    rd16(3'd0, 16'h0000, "R1 counter");
    rd16(3'd2, 16'h0000, "R1 compare A");
    rd16(3'd4, 16'h0000, "R1 compare B");

    // R4: high write alone parks the byte, register untouched
    bus_wr(3'd1, 8'h12);
    bus_rd(3'd1, 8'h12, "R4 holding byte");
    bus_rd(3'd0, 8'h00, "R4 counter low unchanged");
    bus_rd(3'd1, 8'h00, "R4 counter high unchanged");
    wr16(3'd0, 16'h1234);
    rd16(3'd0, 16'h1234, "R4 counter committed");

    // R6: high byte written for B lands in A on A's low write
    bus_wr(3'd5, 8'hAB);
    bus_wr(3'd2, 8'hCD);
    rd16(3'd2, 16'hABCD, "R6 compare A from shared byte");
    rd16(3'd4, 16'h0000, "R6 compare B untouched");

    // R5: low read latches, a later high write to another slot overrides
    bus_rd(3'd0, 8'h34, "R5 counter low");
    bus_wr(3'd3, 8'h77);
    bus_rd(3'd1, 8'h77, "R5 high read returns shared byte");
    rd16(3'd2, 16'hABCD, "R5 compare A intact");

    // R2: increments and holds
    wr16(3'd0, 16'h0010);
    ticks(5);
    rd16(3'd0, 16'h0015, "R2 after five ticks");
    repeat (3) @(negedge clk);
    rd16(3'd0, 16'h0015, "R2 hold without tick");

    // R3: wrap
    wr16(3'd0, 16'hFFFE);
    ticks(2);
    rd16(3'd0, 16'h0000, "R3 wrap");
    check("R3 no flags", {14'd0, cmp_flag}, 16'h0);

    // R7: matches on A then B
    wr16(3'd2, 16'h0105);
    wr16(3'd4, 16'h0107);
    wr16(3'd0, 16'h0100);
    ticks(6);
    check("R7 flag A only", {14'd0, cmp_flag}, 16'h1);
    check("R7 wave A only", {14'd0, wave_out}, 16'h1);
    ticks(2);
    check("R7 both flags", {14'd0, cmp_flag}, 16'h3);
    check("R7 both waves", {14'd0, wave_out}, 16'h3);
    rd16(3'd0, 16'h0108, "R7 count after matches");

    // R8: flag register read and write-one-to-clear
    bus_rd(3'd6, 8'h03, "R8 flag readback");
    bus_wr(3'd6, 8'h02);
    check("R8 clear B", {14'd0, cmp_flag}, 16'h1);
    bus_wr(3'd6, 8'h00);
    check("R8 zero write no effect", {14'd0, cmp_flag}, 16'h1);
    bus_wr(3'd6, 8'h01);
    check("R8 clear A", {14'd0, cmp_flag}, 16'h0);
    check("R8 waves kept", {14'd0, wave_out}, 16'h3);

    // R9: load suppresses next enabled compare
    wr16(3'd0, 16'h0105);
    ticks(1);
    check("R9 A suppressed", {14'd0, cmp_flag}, 16'h0);
    check("R9 A wave held", {14'd0, wave_out}, 16'h3);
    rd16(3'd0, 16'h0106, "R9 count advanced");
    wr16(3'd0, 16'h0107);
    ticks(1);
    check("R9 B suppressed", {14'd0, cmp_flag}, 16'h0);
    wr16(3'd0, 16'h0104);
    ticks(2);
    check("R9 match resumes", {14'd0, cmp_flag}, 16'h1);
    check("R9 wave A toggled", {14'd0, wave_out}, 16'h2);
    bus_wr(3'd6, 8'h03);
    check("R8 cleared before race", {14'd0, cmp_flag}, 16'h0);

    // R8: match beats simultaneous clear
    wr16(3'd0, 16'h0103);
    ticks(2);
    bus_addr = 3'd6; bus_wdata = 8'h01; bus_we = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    check("R8 set wins over clear", {14'd0, cmp_flag}, 16'h1);
    check("R7 wave A toggled back", {14'd0, wave_out}, 16'h3);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule